// File: doc/BRIEF.md
# Subranging ADC digital correction back end

This block is the digital tail of a two-step subranging converter. On every rising encode edge it takes the 5-bit coarse estimate, the 6-bit fine residue and the two out-of-range comparator outputs. The coarse and fine ranges overlap by half a coarse step. The block combines the two codes into a single 10-bit word and takes the overlap out in the process. When the input lies outside the convertible range, it forces the word to the matching full-scale code.

The result is presented in two's complement by default, or in offset binary when the format bit is set. It leaves through a fixed three-edge output pipeline, and the out-of-range flag travels with it. A separate valid output goes low on reset or when the encode clock is restarted. It rises again only once the pipeline holds fresh samples.

Top module: `adc_subrange_backend`

## Requirements
- R1: The offset-binary value is coarse*32 + fine - 16. In two's-complement mode the output word is that value with bit 9 inverted, so offset 512 gives 0x000 and offset 0 gives 0x200.
- R2: A sample presented at encode rising edge N appears on `data_out` and `oor_out` right after rising edge N+3, and stays there until edge N+4.
- R3: When `ovr_hi` is set, or the merged value exceeds 1023, the output is the positive full-scale code and `oor_out` is 1. That code is 0x1FF in two's complement and 0x3FF in offset binary. When `ovr_hi` and `ovr_lo` are both set, `ovr_hi` wins.
- R4: When only `ovr_lo` is set, or the merged value is below 0, the output is the negative full-scale code and `oor_out` is 1. That code is 0x200 in two's complement and 0x000 in offset binary.
- R5: For an in-range sample with neither comparator set, `oor_out` is 0. The flag always belongs to the word output in the same cycle.
- R6: With `bin_mode` = 1 at a sample's edge, that sample's word is output in offset binary, with bit 9 not inverted. The mode bit travels with its sample.
- R7: After a rising edge with `rst` high, `data_out` is 0, `oor_out` is 0 and `valid_out` is 0.
- R8: After a rising edge with `restart` high, `valid_out` is 0. It rises right after the fourth following edge at which neither `restart` nor `rst` is high. A restart does not disturb the data path.
- R9: Once high, `valid_out` stays high as long as neither `restart` nor `rst` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Encode clock has just restarted; pipeline contents are stale |
| coarse_code | input | 5 | Coarse quantizer code |
| fine_code | input | 6 | Fine residue quantizer code |
| ovr_hi | input | 1 | Positive overrange comparator |
| ovr_lo | input | 1 | Negative overrange comparator |
| bin_mode | input | 1 | 1 selects offset binary output, 0 two's complement |
| data_out | output | 10 | Corrected sample word |
| oor_out | output | 1 | Out-of-range flag aligned with `data_out` |
| valid_out | output | 1 | Pipeline holds fresh samples |

## Verification
The bench drives each sample on a falling edge, so the rising edge that follows captures it. Each sample's word and flag are due right after the third rising edge after that capture. The bench therefore compares them at the fourth falling edge after driving. To do this it keeps a four-entry queue of expected results, and a reset clears the queue entries it makes stale. The valid flag is due one edge after the control it reacts to. A bench edge counter predicts it, and it is compared at every falling edge. The reset state is checked at the first falling edge after a reset edge.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // saturation decision for one sample
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_e;
endpackage

// File: rtl/adc_corr_merge.sv
module adc_corr_merge
  import adc_corr_pkg::*;
#(
  parameter int CW = 5,
  parameter int FW = 6,
  parameter int OW = CW + FW - 1
) (
  input  logic [CW-1:0] coarse,
  input  logic [FW-1:0] fine,
  input  logic          ovr_hi,
  input  logic          ovr_lo,
  input  logic          bin_mode,
  output logic [OW-1:0] code,
  output logic          oor
);
  localparam int SUMW = OW + 2;
  localparam int OVL  = 1 << (FW - 2);
  localparam int MAXC = (1 << OW) - 1;
  localparam logic signed [SUMW-1:0] MAXV = SUMW'(MAXC);

  logic [SUMW-1:0]        c_ext, f_ext;
  logic signed [SUMW-1:0] raw;
  sat_e                   sat;
  logic [OW-1:0]          off;

  always_comb begin
    c_ext = SUMW'(coarse) << (FW - 1);
    f_ext = SUMW'(fine);
    raw   = $signed(c_ext + f_ext - SUMW'(OVL));
  end

  // comparators take precedence over arithmetic overflow; high beats low
  always_comb begin
    if (ovr_hi)             sat = SAT_HI;
    else if (ovr_lo)        sat = SAT_LO;
    else if (raw[SUMW-1])   sat = SAT_LO;
    else if (raw > MAXV)    sat = SAT_HI;
    else                    sat = SAT_NONE;
  end

  always_comb begin
    unique case (sat)
      SAT_HI:  off = '1;
      SAT_LO:  off = '0;
      default: off = raw[OW-1:0];
    endcase
    code = bin_mode ? off : {~off[OW-1], off[OW-2:0]};
    oor  = (sat != SAT_NONE);
  end
endmodule

// File: rtl/adc_pipe_delay.sv
module adc_pipe_delay #(
  parameter int W     = 11,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] st [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) st[i] <= '0;
        end else begin
          st[0] <= d;
          for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
        end
      end
      assign q = st[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/adc_flush_track.sv
module adc_flush_track #(
  parameter int FILL = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic valid
);
  localparam int CNT_W = $clog2(FILL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILL);
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(FILL - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt   <= '0;
      valid <= 1'b0;
    end else begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      valid <= (cnt >= PRE);
    end
  end
endmodule

// File: rtl/adc_subrange_backend.sv
module adc_subrange_backend #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 6,
  parameter int LATENCY  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       restart,
  input  logic [COARSE_W-1:0]        coarse_code,
  input  logic [FINE_W-1:0]          fine_code,
  input  logic                       ovr_hi,
  input  logic                       ovr_lo,
  input  logic                       bin_mode,
  output logic [COARSE_W+FINE_W-2:0] data_out,
  output logic                       oor_out,
  output logic                       valid_out
);
  localparam int OUT_W = COARSE_W + FINE_W - 1;
  localparam int FILL  = LATENCY + 1;

  // capture stage: the encode edge samples the quantizer outputs
  logic [COARSE_W-1:0] cap_c;
  logic [FINE_W-1:0]   cap_f;
  logic                cap_hi, cap_lo, cap_bin;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_c   <= '0;
      cap_f   <= '0;
      cap_hi  <= 1'b0;
      cap_lo  <= 1'b0;
      cap_bin <= 1'b0;
    end else begin
      cap_c   <= coarse_code;
      cap_f   <= fine_code;
      cap_hi  <= ovr_hi;
      cap_lo  <= ovr_lo;
      cap_bin <= bin_mode;
    end
  end

  logic [OUT_W-1:0] m_code;
  logic             m_oor;

  adc_corr_merge #(.CW(COARSE_W), .FW(FINE_W), .OW(OUT_W)) u_merge (
    .coarse   (cap_c),
    .fine     (cap_f),
    .ovr_hi   (cap_hi),
    .ovr_lo   (cap_lo),
    .bin_mode (cap_bin),
    .code     (m_code),
    .oor      (m_oor)
  );

  // word and flag share one shift path so they cannot drift apart
  logic [OUT_W:0] pipe_q;

  adc_pipe_delay #(.W(OUT_W + 1), .DEPTH(LATENCY)) u_delay (
    .clk (clk),
    .rst (rst),
    .d   ({m_code, m_oor}),
    .q   (pipe_q)
  );

  assign data_out = pipe_q[OUT_W:1];
  assign oor_out  = pipe_q[0];

  adc_flush_track #(.FILL(FILL)) u_flush (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .valid   (valid_out)
  );
endmodule

// File: rtl/adc_subrange_backend_chk.sv
module adc_subrange_backend_chk #(
  parameter int OUT_W   = 10,
  parameter int LATENCY = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             ovr_hi,
  input logic             ovr_lo,
  input logic [OUT_W-1:0] data_out,
  input logic             oor_out,
  input logic             valid_out
);
  localparam int FILL  = LATENCY + 1;
  localparam int CNT_W = $clog2(FILL + 1);

  // comparator history, one slot per edge, with a marker for reset-free slots
  logic [LATENCY:0] sh_hi, sh_lo, sh_ok;
  logic [CNT_W-1:0] since_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_hi <= '0;
      sh_lo <= '0;
      sh_ok <= '0;
    end else begin
      sh_hi <= {sh_hi[LATENCY-1:0], ovr_hi};
      sh_lo <= {sh_lo[LATENCY-1:0], ovr_lo};
      sh_ok <= {sh_ok[LATENCY-1:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart)               since_clr <= '0;
    else if (since_clr != CNT_W'(FILL)) since_clr <= since_clr + 1'b1;
  end

  logic lo_ones, lo_zero;
  assign lo_ones = &data_out[OUT_W-2:0];
  assign lo_zero = ~|data_out[OUT_W-2:0];

  assert_pos_sat_R3: assert property (@(posedge clk) disable iff (rst)
    (sh_ok[LATENCY] && sh_hi[LATENCY]) |-> (oor_out && lo_ones));

  assert_neg_sat_R4: assert property (@(posedge clk) disable iff (rst)
    (sh_ok[LATENCY] && !sh_hi[LATENCY] && sh_lo[LATENCY]) |-> (oor_out && lo_zero));

  assert_flag_code_R5: assert property (@(posedge clk) disable iff (rst)
    oor_out |-> (lo_ones || lo_zero));

  assert_restart_drop_R8: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> !valid_out);

  assert_refill_R8: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> (since_clr == CNT_W'(FILL)));

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !restart) |=> valid_out);
endmodule

bind adc_subrange_backend adc_subrange_backend_chk #(
  .OUT_W   (OUT_W),
  .LATENCY (LATENCY)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .restart   (restart),
  .ovr_hi    (ovr_hi),
  .ovr_lo    (ovr_lo),
  .data_out  (data_out),
  .oor_out   (oor_out),
  .valid_out (valid_out)
);

// File: tb/adc_subrange_backend_tb.sv
`timescale 1ns/1ps
module adc_subrange_backend_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       restart = 1'b0;
  logic [4:0] coarse_code = '0;
  logic [5:0] fine_code = '0;
  logic       ovr_hi = 1'b0, ovr_lo = 1'b0, bin_mode = 1'b0;
  logic [9:0] data_out;
  logic       oor_out, valid_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  adc_subrange_backend u_dut (
    .clk(clk), .rst(rst), .restart(restart),
    .coarse_code(coarse_code), .fine_code(fine_code),
    .ovr_hi(ovr_hi), .ovr_lo(ovr_lo), .bin_mode(bin_mode),
    .data_out(data_out), .oor_out(oor_out), .valid_out(valid_out)
  );

  // expected-result queue: slot 3 is the sample due now
  logic [10:0] h_exp [4];
  bit          h_ok  [4];
  string       h_tag [4];
  int          vcnt = 0;
  bit          exp_valid = 1'b0;
  bit          prev_rst = 1'b0;

  function automatic logic [10:0] model(int c, int f, bit hi, bit lo, bit m);
    int raw = c * 32 + f - 16;
    int off;
    bit o;
    if (hi)              begin off = 1023; o = 1; end
    else if (lo)         begin off = 0;    o = 1; end
    else if (raw > 1023) begin off = 1023; o = 1; end
    else if (raw < 0)    begin off = 0;    o = 1; end
    else                 begin off = raw;  o = 0; end
    if (!m) off = off ^ 512;
    return {o, off[9:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int c, int f, bit hi, bit lo, bit m, bit rs, bit rsr, string tag);
    @(negedge clk);
    if (prev_rst) begin
      chk(data_out == 10'h000, "R7 data", data_out, 0);
      chk(oor_out == 1'b0, "R7 oor", oor_out, 0);
    end
    if (h_ok[3]) begin
      chk(data_out == h_exp[3][9:0], {h_tag[3], " data"}, data_out, h_exp[3][9:0]);
      chk(oor_out == h_exp[3][10], {h_tag[3], " oor"}, oor_out, h_exp[3][10]);
    end
    chk(valid_out == exp_valid, exp_valid ? "R9 valid" : "R8 valid", valid_out, exp_valid);
    coarse_code = 5'(c); fine_code = 6'(f);
    ovr_hi = hi; ovr_lo = lo; bin_mode = m; rst = rs; restart = rsr;
    for (int i = 3; i > 0; i--) begin
      h_exp[i] = h_exp[i-1]; h_ok[i] = h_ok[i-1]; h_tag[i] = h_tag[i-1];
    end
    h_exp[0] = model(c, f, hi, lo, m);
    h_ok[0]  = !rs;
    h_tag[0] = tag;
    if (rs) for (int i = 1; i < 4; i++) h_ok[i] = 1'b0;
    if (rs || rsr) vcnt = 0;
    else if (vcnt < 4) vcnt++;
    exp_valid = (vcnt == 4);
    prev_rst = rs;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin h_exp[i] = '0; h_ok[i] = 1'b0; h_tag[i] = ""; end
    void'($urandom(32'd4242));
    repeat (3) step(0, 0, 0, 0, 0, 1, 0, "R7");
    // directed: merge and format (R1, R5, R6)
    step(16, 16, 0, 0, 0, 0, 0, "R1");   // offset 512 -> 0x000
    step(0, 16, 0, 0, 0, 0, 0, "R1");    // offset 0   -> 0x200
    step(31, 47, 0, 0, 0, 0, 0, "R1");   // offset 1023 in range
    step(0, 17, 0, 0, 0, 0, 0, "R5");    // offset 1, flag low
    step(16, 16, 0, 0, 1, 0, 0, "R6");   // binary: 0x200
    step(31, 47, 0, 0, 1, 0, 0, "R6");   // binary: 0x3FF, flag low
    // directed saturation (R3, R4)
    step(31, 63, 0, 0, 0, 0, 0, "R3");   // 1039 clamps high
    step(31, 48, 0, 0, 0, 0, 0, "R3");   // 1024 clamps high
    step(0, 0, 0, 0, 0, 0, 0, "R4");     // -16 clamps low
    step(0, 15, 0, 0, 0, 0, 0, "R4");    // -1 clamps low
    step(0, 0, 1, 0, 0, 0, 0, "R3");     // comparator high overrides code
    step(31, 63, 0, 1, 0, 0, 0, "R4");   // comparator low overrides code
    step(10, 20, 1, 1, 0, 0, 0, "R3");   // both: high wins
    step(5, 5, 1, 0, 1, 0, 0, "R3");     // binary high sat 0x3FF
    step(20, 5, 0, 1, 1, 0, 0, "R4");    // binary low sat 0x000
    // random mix, alignment through the pipeline (R2)
    for (int n = 0; n < 300; n++) begin
      int r = int'($urandom_range(0, 15));
      step(int'($urandom_range(0, 31)), int'($urandom_range(0, 63)),
           r == 0, r == 1, bit'($urandom_range(0, 1)), 0, 0, "R2");
    end
    // clock restart mid-stream: valid drops and refills, data keeps flowing (R8)
    step(12, 30, 0, 0, 0, 0, 1, "R8");
    for (int n = 0; n < 6; n++)
      step(int'($urandom_range(0, 31)), int'($urandom_range(0, 63)), 0, 0, 0, 0, 0, "R8");
    step(3, 40, 0, 0, 0, 0, 1, "R8");
    step(4, 40, 0, 0, 0, 0, 0, "R8");
    step(5, 40, 0, 0, 0, 0, 1, "R8");    // restart again during refill
    for (int n = 0; n < 8; n++)
      step(int'($urandom_range(0, 31)), int'($urandom_range(0, 63)), 0, 0, 1, 0, 0, "R9");
    // mid-run reset (R7)
    step(31, 63, 1, 0, 0, 1, 0, "R7");
    for (int n = 0; n < 40; n++) begin
      int r = int'($urandom_range(0, 7));
      step(int'($urandom_range(0, 31)), int'($urandom_range(0, 63)),
           r == 0, r == 1, bit'($urandom_range(0, 1)), 0, 0, "R2");
    end
    repeat (5) step(0, 16, 0, 0, 0, 0, 0, "R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule